// File: doc/BRIEF.md
# Serial-in latched parallel-out register

This block is a double-buffered serial-to-parallel converter. A serial bit stream is clocked into a shift stage on one clock. A separate storage clock copies the whole shift stage, in one step, into a storage register that drives the parallel outputs. Shifting never disturbs what the outputs show until the next storage edge, so a host can load a new word bit by bit while the old word stays on the pins.

The parallel outputs can be switched to high impedance with an active-low enable. The last shift bit also leaves the block as a serial cascade output, so several instances in a row form one longer chain. An active-low clear empties the shift stage at once and leaves the storage register alone. Its release is synchronised to the shift clock, and a set number of shift edges after release are dropped.

Top module: `sipo_latch_reg`

## Requirements
- R1: While `clr_n` is low, every shift-stage bit is 0 at once, `casc_out` reads 0 and shift-clock edges have no effect.
- R2: On each counted rising edge of `shift_clk`, shift bit n takes the old value of bit n-1 and bit 0 takes `ser_in`.
- R3: `casc_out` always equals shift bit WIDTH-1 and is not affected by `oe_n`.
- R4: A rising edge of `store_clk` copies all shift bits into the storage register; `par_out[i]` shows shift bit i, so `par_out[0]` is the most recent serial bit.
- R5: The storage register changes only on `store_clk` edges; shift edges and `clr_n` leave it untouched.
- R6: With `oe_n` high, every `par_out` bit is high impedance; with `oe_n` low, `par_out` drives the storage contents. Toggling `oe_n` does not alter them.
- R7: When both clocks rise together, the storage register takes the shift value from before that edge, so it lags the shift stage by one edge.
- R8: After `clr_n` rises, the first SYNC_STAGES rising edges of `shift_clk` (1 by default) are dropped; shifting resumes on the next edge.
- R9: The storage register holds all zeros from the start of simulation until its first `store_clk` edge.
- R10: Two instances sharing clocks, with `casc_out` of the first wired to `ser_in` of the second, behave as one 2*WIDTH-bit shift chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk | input | 1 | Rising-edge clock of the shift stage |
| store_clk | input | 1 | Rising-edge clock of the storage register |
| clr_n | input | 1 | Active-low clear of the shift stage; asserts asynchronously, releases in step with `shift_clk` |
| ser_in | input | 1 | Serial data bit |
| oe_n | input | 1 | Active-low enable of the parallel outputs |
| par_out | output | WIDTH | Storage register contents, or high impedance |
| casc_out | output | 1 | Last shift bit, for the next instance in a chain |

## Verification
The hardest state to reach from the pins is the edge that comes right after the clear is released. A correct design drops that edge while a naive one shifts it in. The bench lets the clear go between clock edges, sends a 1 on the next shift edge and then pulses the storage clock. A zero word proves the edge was dropped. The bench also asserts the clear in the middle of a word while shift edges keep coming. It ties both clocks together so that each storage edge must capture the value from before the shift.

// File: rtl/sipo_latch_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults for the serial-in latched parallel-out register.
// Assumes: nothing; holds only constants used as parameter defaults.
package sipo_latch_pkg;
    localparam int unsigned SIPO_WIDTH_DEF = 8;   // parallel word width
    localparam int unsigned SIPO_SYNC_DEF  = 1;   // dropped shift edges after clear release
endpackage

// File: rtl/sipo_clr_sync.sv
`timescale 1ns/1ps
// Module: sipo_clr_sync
// Brings the release of the active-low clear into the shift clock domain.
// Assertion of the clear is asynchronous; run_o rises only after STAGES
// shift-clock edges with the clear high, so those edges do not shift.
// Assumes: STAGES >= 1.
module sipo_clr_sync #(
    parameter int unsigned STAGES = sipo_latch_pkg::SIPO_SYNC_DEF
) (
    input  logic shift_clk,
    input  logic clr_n,
    output logic run_o
);
    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: one-flop release stage.
            always_ff @(posedge shift_clk or negedge clr_n) begin
                if (!clr_n) sync_q <= '0;
                else        sync_q <= 1'b1;
            end
        end else begin : g_chain
            // Purpose: multi-flop release chain, filled with ones from bit 0.
            always_ff @(posedge shift_clk or negedge clr_n) begin
                if (!clr_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign run_o = sync_q[STAGES-1];
endmodule

// File: rtl/sipo_shift_stage.sv
`timescale 1ns/1ps
// Module: sipo_shift_stage
// Serial-in shift stage. Bit 0 takes the serial input, each other bit takes
// its lower neighbour. Clear empties it asynchronously; shifting occurs only
// while run_i (the synchronised release) is high.
// Assumes: WIDTH >= 2; clr_n does not change on a shift_clk edge.
module sipo_shift_stage #(
    parameter int unsigned WIDTH = sipo_latch_pkg::SIPO_WIDTH_DEF
) (
    input  logic             shift_clk,
    input  logic             clr_n,
    input  logic             run_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] bits_o,
    output logic             casc_o
);
    logic [WIDTH-1:0] bits_q;

    // Purpose: clear or shift the stage.
    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n)     bits_q <= '0;
        else if (run_i) bits_q <= {bits_q[WIDTH-2:0], ser_i};
    end

    assign bits_o = bits_q;
    assign casc_o = bits_q[WIDTH-1];

    AST_SHIFT_MOVES: assert property (@(posedge shift_clk) disable iff (!run_i)
        1'b1 |=> (bits_q[WIDTH-1:1] == $past(bits_q[WIDTH-2:0]))); // R2

    AST_CASC_FOLLOWS: assert property (@(posedge shift_clk) disable iff (!run_i)
        1'b1 |=> (casc_o == $past(bits_q[WIDTH-2]))); // R3

    // Purpose: stage stays empty while cleared or waiting for release.
    always @(posedge shift_clk) begin
        if (!clr_n) begin
            AST_CLEAR_EMPTY: assert (bits_q == '0 && casc_o == 1'b0); // R1
        end else if (!run_i) begin
            AST_RELEASE_HOLD: assert (bits_q == '0); // R8
        end
    end
endmodule

// File: rtl/sipo_store_reg.sv
`timescale 1ns/1ps
// Module: sipo_store_reg
// Storage register loaded in parallel from the shift stage on each rising
// storage-clock edge. It has no reset; it starts at zero in simulation.
// Assumes: shift data is settled before a store edge, or the clocks are tied.
module sipo_store_reg #(
    parameter int unsigned WIDTH = sipo_latch_pkg::SIPO_WIDTH_DEF
) (
    input  logic             store_clk,
    input  logic [WIDTH-1:0] bits_i,
    output logic [WIDTH-1:0] held_o
);
    logic [WIDTH-1:0] held_q = '0;

    // Purpose: capture the whole shift stage.
    always_ff @(posedge store_clk) begin
        held_q <= bits_i;
    end

    assign held_o = held_q;
endmodule

// File: rtl/sipo_out_drv.sv
`timescale 1ns/1ps
// Module: sipo_out_drv
// Three-state driver for the parallel outputs, one driver per bit.
// Assumes: oe_n is active low.
module sipo_out_drv #(
    parameter int unsigned WIDTH = sipo_latch_pkg::SIPO_WIDTH_DEF
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] held_i,
    output logic [WIDTH-1:0] pads_o
);
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            // Purpose: drive or float one output bit.
            assign pads_o[g] = oe_n ? 1'bz : held_i[g];
        end
    endgenerate
endmodule

// File: rtl/sipo_latch_reg.sv
`timescale 1ns/1ps
// Module: sipo_latch_reg (top)
// Serial-in shift stage feeding a storage register on its own clock, with
// three-state parallel outputs and a serial cascade output.
// Assumes: clr_n and oe_n are not changed on a clock edge.
module sipo_latch_reg #(
    parameter int unsigned WIDTH       = sipo_latch_pkg::SIPO_WIDTH_DEF,
    parameter int unsigned SYNC_STAGES = sipo_latch_pkg::SIPO_SYNC_DEF
) (
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             clr_n,
    input  logic             ser_in,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_out,
    output logic             casc_out
);
    logic             run;
    logic [WIDTH-1:0] sh_bits;
    logic [WIDTH-1:0] held;

    sipo_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .shift_clk (shift_clk),
        .clr_n     (clr_n),
        .run_o     (run)
    );

    sipo_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .shift_clk (shift_clk),
        .clr_n     (clr_n),
        .run_i     (run),
        .ser_i     (ser_in),
        .bits_o    (sh_bits),
        .casc_o    (casc_out)
    );

    sipo_store_reg #(.WIDTH(WIDTH)) u_store (
        .store_clk (store_clk),
        .bits_i    (sh_bits),
        .held_o    (held)
    );

    sipo_out_drv #(.WIDTH(WIDTH)) u_drv (
        .oe_n      (oe_n),
        .held_i    (held),
        .pads_o    (par_out)
    );
endmodule

// File: tb/sipo_latch_reg_bench.sv
`timescale 1ns/1ps
module sipo_latch_reg_bench;
    localparam int W    = 8;
    localparam int SYNC = 1;

    logic shift_clk = 1'b0;
    logic store_clk = 1'b0;
    logic clr_n     = 1'b1;
    logic ser_in    = 1'b0;
    logic oe_n      = 1'b0;
    logic [W-1:0] par_lo, par_hi;
    logic casc_lo, casc_hi;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model of the two-instance chain
    logic [2*W-1:0] m_sr = '0;
    logic [2*W-1:0] m_st = '0;
    int ign = 0;

    sipo_latch_reg #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_sipo_latch_reg (
        .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n),
        .ser_in(ser_in), .oe_n(oe_n), .par_out(par_lo), .casc_out(casc_lo));

    sipo_latch_reg #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_sipo_latch_reg_next (
        .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n),
        .ser_in(casc_lo), .oe_n(oe_n), .par_out(par_hi), .casc_out(casc_hi));

    // stimulus table: word[9:2], oe_n[1], tied clocks[0]
    localparam logic [9:0] VEC [6] = '{
        {8'hA5, 1'b0, 1'b0},
        {8'h3C, 1'b0, 1'b1},
        {8'hFF, 1'b1, 1'b0},
        {8'h00, 1'b0, 1'b1},
        {8'h81, 1'b0, 1'b0},
        {8'h5A, 1'b1, 1'b1}
    };

    task automatic check(input string req);
        logic [W-1:0] e_lo, e_hi;
        e_lo = oe_n ? {W{1'bz}} : m_st[W-1:0];
        e_hi = oe_n ? {W{1'bz}} : m_st[2*W-1:W];
        n_tests++;
        if (par_lo !== e_lo || par_hi !== e_hi ||
            casc_lo !== m_sr[W-1] || casc_hi !== m_sr[2*W-1]) begin
            n_fail++;
            $display("FAIL %s: par %b/%b casc %b/%b, expected par %b/%b casc %b/%b",
                     req, par_hi, par_lo, casc_hi, casc_lo,
                     e_hi, e_lo, m_sr[2*W-1], m_sr[W-1]);
        end
    endtask

    task automatic pulse_shift(input logic b, input logic tied);
        ser_in = b;
        #1;
        if (tied) m_st = m_sr;
        if (clr_n) begin
            if (ign > 0) ign--;
            else m_sr = {m_sr[2*W-2:0], b};
        end
        shift_clk = 1'b1;
        if (tied) store_clk = 1'b1;
        #2.5;
        shift_clk = 1'b0;
        store_clk = 1'b0;
        #1.5;
    endtask

    task automatic pulse_store();
        #1;
        m_st = m_sr;
        store_clk = 1'b1;
        #2.5;
        store_clk = 1'b0;
        #1.5;
    endtask

    task automatic set_clear(input logic v);
        clr_n = v;
        if (!v) m_sr = '0;
        else    ign = SYNC;
        #2;
    endtask

    task automatic send_word(input logic [W-1:0] w, input logic tied);
        for (int i = W-1; i >= 0; i--) begin
            pulse_shift(w[i], tied);
            check(tied ? "R7" : "R3");
        end
    endtask

    initial begin
        #2;
        set_clear(1'b0);
        check("R9");                      // storage zero, shift empty
        pulse_shift(1'b1, 1'b0);
        check("R1");                      // edge during clear ignored

        // R8: first edge after release is dropped
        set_clear(1'b1);
        pulse_shift(1'b1, 1'b0);
        pulse_store();
        check("R8");
        pulse_shift(1'b1, 1'b0);
        pulse_store();
        check("R2");

        // table walk
        for (int v = 0; v < 6; v++) begin
            oe_n = VEC[v][1];
            #1;
            send_word(VEC[v][9:2], VEC[v][0]);
            if (!VEC[v][0]) begin
                check("R5");              // shifting left storage alone
                pulse_store();
            end
            check(VEC[v][1] ? "R6" : "R4");
        end

        // R6: enable toggling keeps contents
        oe_n = 1'b0; #1; check("R6");
        oe_n = 1'b1; #1; check("R6");
        oe_n = 1'b0; #1; check("R6");

        // R10: 16-bit chain across two instances
        for (int i = 15; i >= 0; i--) pulse_shift(16'hC3E1 >> i, 1'b0);
        pulse_store();
        check("R10");

        // R1 / R5: clear mid-stream, storage untouched
        pulse_shift(1'b1, 1'b0);
        pulse_shift(1'b0, 1'b0);
        pulse_shift(1'b1, 1'b0);
        set_clear(1'b0);
        check("R5");
        pulse_shift(1'b1, 1'b0);
        pulse_shift(1'b1, 1'b0);
        check("R1");
        set_clear(1'b1);
        pulse_shift(1'b1, 1'b1);          // dropped edge with tied clocks
        check("R8");
        pulse_store();
        check("R1");
        send_word(8'h96, 1'b0);
        pulse_store();
        check("R2");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule